// File: doc/BRIEF.md
# Interrupt Acknowledge and Retirement Unit

This unit sits between an interrupt distributor and one processor core. Each cycle it looks at the pending vector and per-interrupt priorities that the distributor supplies. It picks the most urgent interrupt that is neither masked nor already being serviced. While control bit 0 is set and such an interrupt exists, it raises a request line to the core.

Software claims the interrupt by reading the acknowledge register. That read returns the interrupt number and, for software-generated interrupts, the number of the CPU that raised it. The same read marks the interrupt as in service. Software later writes the same value to the end-of-interrupt register to retire it.

In-service interrupts sit on a small last-in, first-out stack. The priority of the top entry is the running priority, and only strictly more urgent interrupts can nest above it. Registered acknowledge and retirement strobes tell the distributor which number was claimed or retired. The distributor uses them to clear edge-style pending state.

Top module: `cpuif_ack`

## Requirements
- R1: After reset the request line is low, control and priority mask read 0, running priority reads 0xFF and an acknowledge read returns 0x3FF.
- R2: Among the candidates, the interrupt with the numerically lowest priority value wins. Equal priorities go to the lowest interrupt number. Interrupts already in service are never candidates.
- R3: An interrupt is a candidate only if its priority value is strictly below both the priority mask (offset 0x04, bits [7:0]) and the running priority.
- R4: The request line is high exactly when control bit 0 (offset 0x00) is set, a candidate exists and the in-service stack is not full.
- R5: A read of offset 0x0C that finds the request line high returns the winner. The interrupt number is in bits [9:0] and the bits above are zero. The read pushes the winner onto the stack. One cycle later the acknowledge strobe is high with the number on the acknowledge ID output. A pushed number is not offered again until it is retired, even if it stays pending.
- R6: A read of offset 0x0C when the request line is low returns 0x3FF and changes nothing: no strobe and no stack change.
- R7: For interrupt numbers below NUM_SGI, bits [12:10] of the acknowledge value carry the requesting CPU number. A retirement write for such a number must carry the same bits.
- R8: A write to offset 0x10 retires the top stack entry only if bits [9:0] match its number (and bits [12:10] match its source, for R7 numbers). It then pops the entry and raises the retirement strobe one cycle later with that number. Any other write there is ignored.
- R9: Offset 0x14 reads the top entry's priority, or 0xFF when the stack is empty. Offset 0x18 reads the winner's acknowledge value, or 0x3FF if there is none, without side effects. This read ignores control bit 0 and stack fullness.
- R10: Offset 0xFC reads a constant packed as product [31:20], architecture [19:16], revision [15:12] and implementer [11:0]. With the default parameters it is 0x5C1230E7.
- R11: An acknowledge read and a matching retirement write in the same cycle both take effect. The top entry is popped and the winner pushed in its place, and both strobes rise together.
- R12: With DEPTH entries in service, the request line stays low and acknowledge reads return 0x3FF, while offset 0x18 still shows the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_rd_i | input | 1 | Register read strobe |
| reg_raddr_i | input | 8 | Read byte offset |
| reg_rdata_o | output | 32 | Read data, same cycle as the strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 8 | Write byte offset |
| reg_wdata_i | input | 32 | Write data |
| pend_i | input | NUM_IRQ | Pending flags from the distributor |
| prio_i | input | NUM_IRQ*8 | Priority of interrupt i in bits [8i+7:8i] |
| sgi_src_i | input | NUM_SGI*3 | Requesting CPU of software interrupt i in bits [3i+2:3i] |
| irq_o | output | 1 | Interrupt request to the core |
| ack_vld_o | output | 1 | Acknowledge strobe to the distributor |
| ack_id_o | output | 10 | Number acknowledged |
| eoi_vld_o | output | 1 | Retirement strobe to the distributor |
| eoi_id_o | output | 10 | Number retired |

## Verification
The acknowledge read and the retirement write can land in the same clock, because they use separate read and write address ports. The bench provokes this with one in-service interrupt and a more urgent one pending. In a single cycle it reads offset 0x0C and writes the matching retirement value. It then judges the result from the returned number, from both strobes being high together with their own numbers, and from the running priority afterwards, which must be the new entry's. Before that, a priority sweep checks selection arithmetically, and the nesting, mismatch and full-stack scenarios check the stack rules.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;
    localparam int SRC_W  = 3;
    localparam int DATA_W = 32;

    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'h3FF;

    localparam logic [7:0] OFS_CTL = 8'h00;
    localparam logic [7:0] OFS_PMR = 8'h04;
    localparam logic [7:0] OFS_ACK = 8'h0C;
    localparam logic [7:0] OFS_EOI = 8'h10;
    localparam logic [7:0] OFS_RPR = 8'h14;
    localparam logic [7:0] OFS_HPP = 8'h18;
    localparam logic [7:0] OFS_IDR = 8'hFC;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
        logic [SRC_W-1:0]  src;
    } svc_ent_t;
endpackage

// File: rtl/cpuif_pick.sv
module cpuif_pick
    import cpuif_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int NUM_SGI = 16
) (
    input  logic [NUM_IRQ-1:0]        pend_i,
    input  logic [NUM_IRQ-1:0]        excl_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    input  logic [NUM_SGI*SRC_W-1:0]  sgi_src_i,
    input  logic [PRIO_W-1:0]         pmr_i,
    input  logic [PRIO_W-1:0]         rpr_i,
    output logic                      found_o,
    output logic [ID_W-1:0]           id_o,
    output logic [PRIO_W-1:0]         prio_o,
    output logic [SRC_W-1:0]          src_o
);
    logic [SRC_W-1:0] src_all [NUM_IRQ];

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
        if (g < NUM_SGI) begin : g_sgi
            assign src_all[g] = sgi_src_i[g*SRC_W +: SRC_W];
        end else begin : g_per
            assign src_all[g] = '0;
        end
    end

    always_comb begin
        logic [PRIO_W-1:0] cur;
        found_o = 1'b0;
        id_o    = '0;
        prio_o  = '1;
        src_o   = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            cur = prio_i[i*PRIO_W +: PRIO_W];
            if (pend_i[i] && !excl_i[i] && (cur < pmr_i) && (cur < rpr_i)
                && (!found_o || (cur < prio_o))) begin
                found_o = 1'b1;
                id_o    = ID_W'(i);
                prio_o  = cur;
                src_o   = src_all[i];
            end
        end
    end
endmodule

// File: rtl/cpuif_stack.sv
module cpuif_stack
    import cpuif_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int DEPTH   = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  svc_ent_t           push_ent_i,
    input  logic               pop_i,
    output svc_ent_t           top_o,
    output logic               empty_o,
    output logic               full_o,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [NUM_IRQ-1:0] mask_o
);
    typedef struct packed {
        svc_ent_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0]     cnt;
    } stk_t;

    stk_t st_d, st_q;

    assign cnt_o   = st_q.cnt;
    assign empty_o = (st_q.cnt == '0);
    assign full_o  = (st_q.cnt == CNT_W'(DEPTH));
    assign top_o   = st_q.ent[IDX_W'(st_q.cnt - 1'b1)];

    always_comb begin
        logic [CNT_W-1:0] base;
        st_d = st_q;
        base = pop_i ? (st_q.cnt - 1'b1) : st_q.cnt;
        if (push_i) begin
            st_d.ent[IDX_W'(base)] = push_ent_i;
            st_d.cnt = base + 1'b1;
        end else begin
            st_d.cnt = base;
        end
    end

    always_comb begin
        mask_o = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            for (int k = 0; k < DEPTH; k++) begin
                if ((CNT_W'(k) < st_q.cnt) && (st_q.ent[k].id == ID_W'(i))) begin
                    mask_o[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cpuif_ack.sv
module cpuif_ack
    import cpuif_pkg::*;
#(
    parameter int          NUM_IRQ   = 32,
    parameter int          NUM_SGI   = 16,
    parameter int          DEPTH     = 4,
    parameter logic [11:0] PART_NUM  = 12'h5C1,
    parameter logic [3:0]  ARCH_VER  = 4'h2,
    parameter logic [3:0]  REV_NUM   = 4'h3,
    parameter logic [11:0] IMPL_CODE = 12'h0E7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_rd_i,
    input  logic [7:0]                reg_raddr_i,
    output logic [31:0]               reg_rdata_o,
    input  logic                      reg_wr_i,
    input  logic [7:0]                reg_waddr_i,
    input  logic [31:0]               reg_wdata_i,
    input  logic [NUM_IRQ-1:0]        pend_i,
    input  logic [NUM_IRQ*8-1:0]      prio_i,
    input  logic [NUM_SGI*3-1:0]      sgi_src_i,
    output logic                      irq_o,
    output logic                      ack_vld_o,
    output logic [9:0]                ack_id_o,
    output logic                      eoi_vld_o,
    output logic [9:0]                eoi_id_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PAD_W = DATA_W - ID_W - SRC_W;

    typedef struct packed {
        logic              en;
        logic [PRIO_W-1:0] pmr;
        logic              ack_vld;
        logic [ID_W-1:0]   ack_id;
        logic              eoi_vld;
        logic [ID_W-1:0]   eoi_id;
    } ctl_t;

    ctl_t st_d, st_q;

    svc_ent_t          top_ent;
    svc_ent_t          new_ent;
    logic              stk_empty, stk_full;
    logic [CNT_W-1:0]  stk_cnt;
    logic [NUM_IRQ-1:0] svc_mask;
    logic              win_found;
    logic [ID_W-1:0]   win_id;
    logic [PRIO_W-1:0] win_prio;
    logic [SRC_W-1:0]  win_src;
    logic [PRIO_W-1:0] run_prio;
    logic              ack_fire, eoi_fire;
    logic [DATA_W-1:0] win_word;
    logic              en_w;

    assign en_w     = st_q.en;
    assign run_prio = stk_empty ? 8'hFF : top_ent.prio;
    assign new_ent  = '{id: win_id, prio: win_prio, src: win_src};
    assign win_word = win_found ? {PAD_W'(0), win_src, win_id}
                                : {PAD_W'(0), SRC_W'(0), SPURIOUS_ID};

    cpuif_pick #(.NUM_IRQ(NUM_IRQ), .NUM_SGI(NUM_SGI)) u_pick (
        .pend_i    (pend_i),
        .excl_i    (svc_mask),
        .prio_i    (prio_i),
        .sgi_src_i (sgi_src_i),
        .pmr_i     (st_q.pmr),
        .rpr_i     (run_prio),
        .found_o   (win_found),
        .id_o      (win_id),
        .prio_o    (win_prio),
        .src_o     (win_src)
    );

    cpuif_stack #(.NUM_IRQ(NUM_IRQ), .DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (ack_fire),
        .push_ent_i (new_ent),
        .pop_i      (eoi_fire),
        .top_o      (top_ent),
        .empty_o    (stk_empty),
        .full_o     (stk_full),
        .cnt_o      (stk_cnt),
        .mask_o     (svc_mask)
    );

    assign irq_o = st_q.en && win_found && !stk_full;

    always_comb begin
        logic id_match;
        logic src_match;
        st_d = st_q;
        st_d.ack_vld = 1'b0;
        st_d.eoi_vld = 1'b0;

        ack_fire = reg_rd_i && (reg_raddr_i == OFS_ACK) && irq_o;

        id_match  = (reg_wdata_i[ID_W-1:0] == top_ent.id);
        src_match = (top_ent.id >= ID_W'(NUM_SGI))
                 || (reg_wdata_i[ID_W +: SRC_W] == top_ent.src);
        eoi_fire  = reg_wr_i && (reg_waddr_i == OFS_EOI) && !stk_empty
                 && id_match && src_match;

        if (ack_fire) begin
            st_d.ack_vld = 1'b1;
            st_d.ack_id  = win_id;
        end
        if (eoi_fire) begin
            st_d.eoi_vld = 1'b1;
            st_d.eoi_id  = top_ent.id;
        end
        if (reg_wr_i && (reg_waddr_i == OFS_CTL)) begin
            st_d.en = reg_wdata_i[0];
        end
        if (reg_wr_i && (reg_waddr_i == OFS_PMR)) begin
            st_d.pmr = reg_wdata_i[PRIO_W-1:0];
        end

        unique case (reg_raddr_i)
            OFS_CTL: reg_rdata_o = {31'b0, st_q.en};
            OFS_PMR: reg_rdata_o = {24'b0, st_q.pmr};
            OFS_ACK: reg_rdata_o = irq_o ? win_word
                                         : {PAD_W'(0), SRC_W'(0), SPURIOUS_ID};
            OFS_RPR: reg_rdata_o = {24'b0, run_prio};
            OFS_HPP: reg_rdata_o = win_word;
            OFS_IDR: reg_rdata_o = {PART_NUM, ARCH_VER, REV_NUM, IMPL_CODE};
            default: reg_rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_vld_o = st_q.ack_vld;
    assign ack_id_o  = st_q.ack_id;
    assign eoi_vld_o = st_q.eoi_vld;
    assign eoi_id_o  = st_q.eoi_id;
endmodule

// File: rtl/cpuif_ack_chk.sv
module cpuif_ack_chk #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic             ack_vld_o,
    input logic             eoi_vld_o,
    input logic             en,
    input logic             full,
    input logic [CNT_W-1:0] depth,
    input logic             reg_rd_i,
    input logic [7:0]       reg_raddr_i
);
    p_irq_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> en);

    p_irq_not_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !full);

    p_depth_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CNT_W'(DEPTH));

    p_ack_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld_o && !eoi_vld_o) |-> (depth == $past(depth) + 1'b1));

    p_eoi_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_vld_o && !ack_vld_o) |-> (depth == $past(depth) - 1'b1));

    p_swap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_vld_o && ack_vld_o) |-> $stable(depth));

    p_ack_from_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld_o |-> $past(reg_rd_i && (reg_raddr_i == 8'h0C)));
endmodule

bind cpuif_ack cpuif_ack_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_o       (irq_o),
    .ack_vld_o   (ack_vld_o),
    .eoi_vld_o   (eoi_vld_o),
    .en          (en_w),
    .full        (stk_full),
    .depth       (stk_cnt),
    .reg_rd_i    (reg_rd_i),
    .reg_raddr_i (reg_raddr_i)
);

// File: tb/cpuif_ack_tb.sv
module cpuif_ack_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 32;
    localparam int NS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0]  reg_raddr = '0, reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NI-1:0] pend = '0;
    logic [7:0]  pr [NI];
    logic [2:0]  sr [NS];
    logic [NI*8-1:0] prio_flat;
    logic [NS*3-1:0] src_flat;
    logic        irq, ack_vld, eoi_vld;
    logic [9:0]  ack_id, eoi_id;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] rv;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NI; i++) prio_flat[i*8 +: 8] = pr[i];
        for (int i = 0; i < NS; i++) src_flat[i*3 +: 3] = sr[i];
    end

    cpuif_ack u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_rd_i(reg_rd), .reg_raddr_i(reg_raddr), .reg_rdata_o(reg_rdata),
        .reg_wr_i(reg_wr), .reg_waddr_i(reg_waddr), .reg_wdata_i(reg_wdata),
        .pend_i(pend), .prio_i(prio_flat), .sgi_src_i(src_flat),
        .irq_o(irq), .ack_vld_o(ack_vld), .ack_id_o(ack_id),
        .eoi_vld_o(eoi_vld), .eoi_id_o(eoi_id)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_raddr = a;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_wr(input logic [7:0] ra, input logic [7:0] wa,
                         input logic [31:0] d, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_raddr = ra;
        reg_wr = 1'b1; reg_waddr = wa; reg_wdata = d;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic set_pend(input int id, input logic v);
        @(negedge clk);
        pend[id] = v;
        #1;
    endtask

    function automatic logic [31:0] nxt();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    // expected winner with nothing in service: strict below mask, lowest value, lowest id
    function automatic logic [31:0] exp_win(input logic [7:0] pmr);
        logic [31:0] w;
        logic [7:0]  best;
        w = 32'h3FF;
        best = 8'hFF;
        for (int i = 0; i < NI; i++) begin
            if (pend[i] && pr[i] < pmr && pr[i] < best) begin
                best = pr[i];
                w = (i < NS) ? ((32'(sr[i]) << 10) | 32'(i)) : 32'(i);
            end
        end
        return w;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] e;
        logic [7:0]  pmr;
        for (int i = 0; i < NI; i++) pr[i] = 8'h00;
        for (int i = 0; i < NS; i++) sr[i] = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        #1 chk("R1 irq", 32'(irq), 32'h0);
        rd(8'h14, rv); chk("R1 rpr", rv, 32'hFF);
        rd(8'h00, rv); chk("R1 ctl", rv, 32'h0);
        rd(8'h04, rv); chk("R1 pmr", rv, 32'h0);
        rd(8'h0C, rv); chk("R1 ack", rv, 32'h3FF);
        rd(8'hFC, rv); chk("R10 id", rv, 32'h5C1230E7);

        wr(8'h00, 32'h1);

        // R2 R3 R4 sweep: winner selection against the mask
        for (int it = 0; it < 64; it++) begin
            @(negedge clk);
            pend = nxt();
            for (int i = 0; i < NI; i++) begin
                e = nxt();
                pr[i] = {e[2:0], 5'b0};
            end
            for (int i = 0; i < NS; i++) begin
                e = nxt();
                sr[i] = e[2:0];
            end
            case (it % 4)
                0: pmr = 8'hFF;
                1: pmr = 8'h80;
                2: pmr = 8'h00;
                default: pmr = 8'h41;
            endcase
            wr(8'h04, 32'(pmr));
            e = exp_win(pmr);
            rd(8'h18, rv); chk("R2 R3 hpp", rv, e);
            chk("R4 irq", 32'(irq), 32'(e != 32'h3FF));
        end

        wr(8'h04, 32'hFF);
        @(negedge clk); pend = '0;
        for (int i = 0; i < NI; i++) pr[i] = 8'hF0;

        // R5 acknowledge of a level interrupt that stays pending
        pr[20] = 8'h80; set_pend(20, 1'b1);
        rd(8'h0C, rv); chk("R5 ack value", rv, 32'd20);
        chk("R5 ack strobe", 32'(ack_vld), 32'h1);
        chk("R5 ack id", 32'(ack_id), 32'd20);
        rd(8'h14, rv); chk("R9 rpr", rv, 32'h80);
        rd(8'h18, rv); chk("R5 not re-offered", rv, 32'h3FF);
        chk("R5 irq low", 32'(irq), 32'h0);

        // R7 nested software interrupt with source bits
        pr[5] = 8'h40; sr[5] = 3'd3; set_pend(5, 1'b1);
        chk("R3 nest irq", 32'(irq), 32'h1);
        rd(8'h18, rv); chk("R9 hpp sgi", rv, 32'hC05);
        rd(8'h0C, rv); chk("R7 ack sgi", rv, 32'hC05);
        set_pend(5, 1'b0);
        rd(8'h14, rv); chk("R9 rpr nest", rv, 32'h40);

        // R3 equal priority does not preempt
        pr[25] = 8'h40; set_pend(25, 1'b1);
        chk("R3 equal prio", 32'(irq), 32'h0);

        // R8 mismatched retirements ignored
        wr(8'h10, 32'd20);
        chk("R8 wrong id", 32'(eoi_vld), 32'h0);
        rd(8'h14, rv); chk("R8 rpr kept", rv, 32'h40);
        wr(8'h10, 32'h805);
        chk("R7 wrong src", 32'(eoi_vld), 32'h0);
        rd(8'h14, rv); chk("R7 rpr kept", rv, 32'h40);
        wr(8'h10, 32'hC05);
        chk("R8 eoi strobe", 32'(eoi_vld), 32'h1);
        chk("R8 eoi id", 32'(eoi_id), 32'd5);
        rd(8'h14, rv); chk("R8 rpr pop", rv, 32'h80);
        chk("R3 irq after pop", 32'(irq), 32'h1);

        // R11 acknowledge and retirement in the same cycle
        rd_wr(8'h0C, 8'h10, 32'd20, rv);
        chk("R11 ack value", rv, 32'd25);
        chk("R11 ack strobe", 32'(ack_vld), 32'h1);
        chk("R11 eoi strobe", 32'(eoi_vld), 32'h1);
        chk("R11 ack id", 32'(ack_id), 32'd25);
        chk("R11 eoi id", 32'(eoi_id), 32'd20);
        @(negedge clk); pend[25] = 1'b0; pend[20] = 1'b0;
        rd(8'h14, rv); chk("R11 rpr", rv, 32'h40);
        wr(8'h10, 32'd25);
        rd(8'h14, rv); chk("R11 rpr empty", rv, 32'hFF);

        // R12 full stack
        for (int k = 0; k < 4; k++) begin
            pr[16+k] = 8'(8'h70 - 8'h10 * k);
            set_pend(16 + k, 1'b1);
            rd(8'h0C, rv); chk("R12 fill ack", rv, 32'(16 + k));
            set_pend(16 + k, 1'b0);
        end
        rd(8'h14, rv); chk("R12 rpr full", rv, 32'h40);
        pr[21] = 8'h10; set_pend(21, 1'b1);
        chk("R12 irq full", 32'(irq), 32'h0);
        rd(8'h0C, rv); chk("R12 ack full", rv, 32'h3FF);
        chk("R6 no strobe", 32'(ack_vld), 32'h0);
        rd(8'h18, rv); chk("R12 hpp full", rv, 32'd21);
        wr(8'h10, 32'd19);
        rd(8'h14, rv); chk("R12 rpr after pop", rv, 32'h50);
        chk("R12 irq after pop", 32'(irq), 32'h1);
        wr(8'h10, 32'd18); wr(8'h10, 32'd17); wr(8'h10, 32'd16);
        rd(8'h14, rv); chk("R8 drained", rv, 32'hFF);

        // R4 R6 disabled signalling
        wr(8'h00, 32'h0);
        rd(8'h00, rv); chk("R4 ctl off", rv, 32'h0);
        chk("R4 irq off", 32'(irq), 32'h0);
        rd(8'h18, rv); chk("R9 hpp while off", rv, 32'd21);
        rd(8'h0C, rv); chk("R6 ack off", rv, 32'h3FF);
        chk("R6 no strobe off", 32'(ack_vld), 32'h0);
        rd(8'h14, rv); chk("R6 rpr unchanged", rv, 32'hFF);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule